// File: doc/BRIEF.md
# Indexed Memory-to-Memory Byte Mover

This block carries out one two-word move between locations of a byte-wide data space. The first instruction word supplies a short unsigned offset. The engine adds that offset to an index pointer presented on its own input, and the sum is the source address. The second word names the destination directly. The engine reads the source byte through a single-port synchronous memory interface and then writes that byte to the destination.

Two address sets get special handling. A source that falls on one of the indirect-access registers moves 00h instead of memory content. A destination that falls on one of the guarded control registers (the program-counter low byte and the three return-stack-top bytes) is refused: no write takes place, and a fault flag accompanies the completion pulse.

The surrounding sequencer hands the two words over a valid/ready handshake. It watches `busy` and `done`, and it may leave any number of idle cycles between the two words.

Top module: `idx_move_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `dst_fault` and `mem_we` are 0 and `iw_ready` is 1.
- R2: In the cycle after the first word is accepted, `mem_addr` equals (index pointer + offset) modulo 2^AW and `mem_we` is 0. The engine keeps that read address until the write cycle.
- R3: The offset is `iw_data[OW-1:0]` of the first word and the destination is `iw_data[AW-1:0]` of the second. All other word bits are ignored.
- R4: A legal move produces exactly one write cycle. It comes two clocks after the edge that accepts the second word, with `mem_addr` = destination and `mem_wdata` = the source byte.
- R5: When the source address is on the indirect-register list (defaults FDFh, FE7h, FEFh), the byte written is 00h.
- R6: When the destination is on the guarded list (defaults FF9h, FFDh, FFEh, FFFh), `mem_we` stays 0 for the whole move. `dst_fault` is 1 in the `done` cycle, and the destination byte is unchanged.
- R7: `done` is a one-cycle pulse in the cycle after the write cycle. `busy` is 1 from the cycle after the first word is accepted until `done` rises, and it is 0 while `done` is 1.
- R8: `iw_ready` is 1 only while the engine is idle or waiting for the second word. Words offered while it is 0 are ignored.
- R9: The index pointer is sampled only on the edge that accepts the first word. Later changes to it do not affect the move.
- R10: Any number of idle cycles may pass between the two words without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iw_valid | input | 1 | Instruction word offered |
| iw_data | input | IW | Instruction word |
| iw_ready | output | 1 | Engine can take a word |
| idx_ptr | input | AW | Index pointer value |
| mem_addr | output | AW | Data-memory address |
| mem_we | output | 1 | Data-memory write enable |
| mem_wdata | output | DW | Data-memory write byte |
| mem_rdata | input | DW | Data-memory read byte, one cycle after address |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_fault | output | 1 | Destination was guarded; no write was made |

## Verification
The bench builds the engine with its default parameters: a 12-bit address, 7-bit offset, 16-bit words, and the default indirect and guarded lists. That size exposes the full 4096-byte space, so an index near the top plus a large offset reaches the modulo wrap. The same size lets both special address sets be hit at their real locations. A cycle-level reference model mirrors the handshake and memory port. With it, the bench covers long gaps between words, an index pointer that changes mid-move, and words held on the bus while the engine is busy.

// File: rtl/idxmov_pkg.sv
package idxmov_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT2 = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } mv_state_t;
endpackage

// File: rtl/idxmov_addr_match.sv
module idxmov_addr_match #(
  parameter int AW = 12,
  parameter int N  = 3,
  parameter logic [N*AW-1:0] LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [N-1:0] eq;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq[i] = (addr == LIST[i*AW +: AW]);
    end
  endgenerate

  assign hit = |eq;
endmodule

// File: rtl/idxmov_src_gen.sv
module idxmov_src_gen #(
  parameter int AW    = 12,
  parameter int OW    = 7,
  parameter int N_IND = 3,
  parameter logic [N_IND*AW-1:0] IND_LIST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] idx,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] src_sum,
  output logic          src_ind_q
);
  localparam int PAD = AW - OW;

  logic ind_hit;

  assign src_sum = idx + {{PAD{1'b0}}, ofs};

  idxmov_addr_match #(.AW(AW), .N(N_IND), .LIST(IND_LIST)) u_ind (
    .addr(src_sum),
    .hit (ind_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)       src_ind_q <= 1'b0;
    else if (load) src_ind_q <= ind_hit;
  end
endmodule

// File: rtl/idxmov_dst_guard.sv
module idxmov_dst_guard #(
  parameter int AW     = 12,
  parameter int N_PROT = 4,
  parameter logic [N_PROT*AW-1:0] PROT_LIST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] dst_in,
  output logic [AW-1:0] dst_q,
  output logic          illegal_q
);
  logic prot_hit;

  idxmov_addr_match #(.AW(AW), .N(N_PROT), .LIST(PROT_LIST)) u_prot (
    .addr(dst_in),
    .hit (prot_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q     <= '0;
      illegal_q <= 1'b0;
    end else if (load) begin
      dst_q     <= dst_in;
      illegal_q <= prot_hit;
    end
  end
endmodule

// File: rtl/idxmov_ctrl.sv
module idxmov_ctrl
  import idxmov_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic iw_valid,
  output logic iw_ready,
  output logic busy,
  output logic w1_acc,
  output logic w2_acc,
  output logic rd_go,
  output logic wr_end
);
  mv_state_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:  if (iw_valid) st <= ST_WAIT2;
        ST_WAIT2: if (iw_valid) st <= ST_READ;
        ST_READ:  st <= ST_WRITE;
        ST_WRITE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign iw_ready = (st == ST_IDLE) || (st == ST_WAIT2);
  assign busy     = (st != ST_IDLE);
  assign w1_acc   = (st == ST_IDLE)  && iw_valid;
  assign w2_acc   = (st == ST_WAIT2) && iw_valid;
  assign rd_go    = (st == ST_READ);
  assign wr_end   = (st == ST_WRITE);
endmodule

// File: rtl/idx_move_engine.sv
module idx_move_engine #(
  parameter int AW     = 12,
  parameter int DW     = 8,
  parameter int IW     = 16,
  parameter int OW     = 7,
  parameter int N_IND  = 3,
  parameter logic [N_IND*AW-1:0] IND_LIST = {12'hFDF, 12'hFE7, 12'hFEF},
  parameter int N_PROT = 4,
  parameter logic [N_PROT*AW-1:0] PROT_LIST = {12'hFFF, 12'hFFE, 12'hFFD, 12'hFF9}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iw_valid,
  input  logic [IW-1:0] iw_data,
  output logic          iw_ready,
  input  logic [AW-1:0] idx_ptr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          dst_fault
);
  logic          w1_acc, w2_acc, rd_go, wr_end;
  logic [AW-1:0] src_sum, dst_q;
  logic          src_ind_q, illegal_q;

  idxmov_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .iw_valid(iw_valid),
    .iw_ready(iw_ready),
    .busy    (busy),
    .w1_acc  (w1_acc),
    .w2_acc  (w2_acc),
    .rd_go   (rd_go),
    .wr_end  (wr_end)
  );

  idxmov_src_gen #(.AW(AW), .OW(OW), .N_IND(N_IND), .IND_LIST(IND_LIST)) u_src (
    .clk      (clk),
    .rst      (rst),
    .load     (w1_acc),
    .idx      (idx_ptr),
    .ofs      (iw_data[OW-1:0]),
    .src_sum  (src_sum),
    .src_ind_q(src_ind_q)
  );

  idxmov_dst_guard #(.AW(AW), .N_PROT(N_PROT), .PROT_LIST(PROT_LIST)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .load     (w2_acc),
    .dst_in   (iw_data[AW-1:0]),
    .dst_q    (dst_q),
    .illegal_q(illegal_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      dst_fault <= 1'b0;
    end else begin
      mem_we    <= rd_go && !illegal_q;
      done      <= wr_end;
      dst_fault <= wr_end && illegal_q;
      if (w1_acc)     mem_addr <= src_sum;
      else if (rd_go) mem_addr <= dst_q;
      if (rd_go)      mem_wdata <= src_ind_q ? '0 : mem_rdata;
    end
  end
endmodule

// File: rtl/idxmov_chk.sv
module idxmov_chk #(
  parameter int AW     = 12,
  parameter int OW     = 7,
  parameter int N_PROT = 4,
  parameter logic [N_PROT*AW-1:0] PROT_LIST = '0
) (
  input logic          clk,
  input logic          rst,
  input logic [OW-1:0] iw_ofs,
  input logic          iw_ready,
  input logic [AW-1:0] idx_ptr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          busy,
  input logic          done,
  input logic          dst_fault
);
  logic [AW-1:0] exp_src;
  logic          addr_guarded;

  assign exp_src = idx_ptr + AW'(iw_ofs);

  always_comb begin
    addr_guarded = 1'b0;
    for (int i = 0; i < N_PROT; i++)
      if (mem_addr == PROT_LIST[i*AW +: AW]) addr_guarded = 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && !mem_we && iw_ready));
  a_r2_src_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!mem_we && mem_addr == $past(exp_src)));
  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  a_r6_no_guarded_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !addr_guarded);
  a_r6_fault_with_done: assert property (@(posedge clk) disable iff (rst)
    dst_fault |-> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
    (done && !dst_fault) |-> $past(mem_we));
  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> iw_ready);
endmodule

bind idx_move_engine idxmov_chk #(
  .AW(AW), .OW(OW), .N_PROT(N_PROT), .PROT_LIST(PROT_LIST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .iw_ofs   (iw_data[OW-1:0]),
  .iw_ready (iw_ready),
  .idx_ptr  (idx_ptr),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .busy     (busy),
  .done     (done),
  .dst_fault(dst_fault)
);

// File: tb/tb_idx_move_engine.sv
`timescale 1ns/1ps
module tb_idx_move_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iw_valid = 1'b0;
  logic [15:0] iw_data = '0;
  logic        iw_ready;
  logic [11:0] idx_ptr = '0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, dst_fault;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run_cmp = 0;

  logic [7:0] bmem [0:4095];

  always #2.5 clk = ~clk;

  idx_move_engine dut (
    .clk(clk), .rst(rst), .iw_valid(iw_valid), .iw_data(iw_data),
    .iw_ready(iw_ready), .idx_ptr(idx_ptr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .dst_fault(dst_fault)
  );

  // synchronous single-port memory
  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] = mem_wdata;
    mem_rdata <= bmem[mem_addr];
  end

  function automatic bit is_ind(int a);
    return (a == 'hFEF) || (a == 'hFE7) || (a == 'hFDF);
  endfunction

  // reference model, advanced on each rising edge
  int         ph = 0;
  int         m_addr = 0, m_dst = 0, m_wdata = 0;
  bit         m_we = 0, m_done = 0, m_err = 0, m_ill = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_addr = 0; m_dst = 0; m_wdata = 0;
      m_we = 0; m_done = 0; m_err = 0; m_ill = 0;
    end else begin
      m_we = 0; m_done = 0; m_err = 0;
      case (ph)
        0: if (iw_valid) begin
             m_addr = (int'(idx_ptr) + int'(iw_data[6:0])) % 4096;
             ph = 1;
           end
        1: if (iw_valid) begin
             m_dst = int'(iw_data[11:0]);
             m_ill = (m_dst == 'hFF9) || (m_dst >= 'hFFD);
             ph = 2;
           end
        2: begin
             m_wdata = is_ind(m_addr) ? 0 : int'(bmem[m_addr]);
             m_addr = m_dst;
             m_we = !m_ill;
             ph = 3;
           end
        default: begin
             m_done = 1; m_err = m_ill; ph = 0;
           end
      endcase
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (run_cmp && !rst) begin
      chk(busy == (ph != 0), "R7", "busy", busy, ph != 0);
      chk(done == m_done, "R7", "done", done, m_done);
      chk(dst_fault == m_err, "R6", "dst_fault", dst_fault, m_err);
      chk(iw_ready == (ph <= 1), "R8", "iw_ready", iw_ready, ph <= 1);
      chk(mem_we == m_we, "R4", "mem_we", mem_we, m_we);
      chk(int'(mem_addr) == m_addr, "R2", "mem_addr", mem_addr, m_addr);
      if (m_we) chk(int'(mem_wdata) == m_wdata, "R4", "mem_wdata", mem_wdata, m_wdata);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [15:0] w);
    @(negedge clk);
    iw_valid = 1'b1; iw_data = w;
    while (!iw_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    iw_valid = 1'b0; iw_data = 16'h0000;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic move(int idx, logic [15:0] w1, logic [15:0] w2,
                      int exp_val, string tag);
    int dst = int'(w2[11:0]);
    @(negedge clk); idx_ptr = 12'(idx);
    send(w1);
    send(w2);
    wait_done();
    chk(int'(bmem[dst]) == exp_val, tag, "dest byte", bmem[dst], exp_val);
  endtask

  initial begin
    int src, ev;
    for (int a = 0; a < 4096; a++) bmem[a] = 8'((a * 7 + 3) ^ (a >> 4));
    bmem['h085] = 8'h33;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !dst_fault && !mem_we && iw_ready, "R1", "reset outputs",
        {busy, done, dst_fault, mem_we, iw_ready}, 5'b00001);
    @(negedge clk); rst = 1'b0; run_cmp = 1;
    chk(!busy && iw_ready, "R1", "after reset", {busy, iw_ready}, 2'b01);

    // R4: basic move, index 80h + 05h -> 85h holding 33h
    move('h080, 16'h0005, 16'h0123, 'h33, "R4");
    chk(idx_ptr == 12'h080, "R9", "index unchanged", idx_ptr, 'h080);

    // R2: offset addition wraps
    src = ('hFF0 + 'h7F) % 4096; ev = bmem[src];
    move('hFF0, 16'h007F, 16'h0300, ev, "R2");

    // R3: upper word bits ignored
    ev = bmem['h105];
    move('h100, 16'hFF85, 16'hF456, ev, "R3");

    // R5: indirect sources read as zero
    bmem['h200] = 8'hA5;
    move('hFE0, 16'h000F, 16'h0200, 0, "R5");
    bmem['h201] = 8'h5A;
    move('hFD0, 16'h000F, 16'h0201, 0, "R5");

    // R6: guarded destinations keep their content
    ev = bmem['hFF9];
    move('h010, 16'h0001, 16'h0FF9, ev, "R6");
    ev = bmem['hFFF];
    move('h020, 16'h0002, 16'h0FFF, ev, "R6");

    // R9 and R10: gap between words, index changes meanwhile
    ev = bmem['h140];
    @(negedge clk); idx_ptr = 12'h100;
    send(16'h0040);
    repeat (6) @(negedge clk);
    idx_ptr = 12'h700;
    send(16'h0555);
    wait_done();
    chk(int'(bmem['h555]) == ev, "R10", "delayed second word", bmem['h555], ev);
    chk(int'(bmem['h555]) != int'(bmem['h740]) || ev == int'(bmem['h740]), "R9",
        "late index ignored", bmem['h555], ev);

    // R8: words held while not ready are ignored
    ev = bmem['h033];
    @(negedge clk); idx_ptr = 12'h030;
    send(16'h0003);
    @(negedge clk); iw_valid = 1'b1; iw_data = 16'h0666;
    @(posedge clk);
    @(negedge clk); iw_data = 16'h0ABC;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); iw_valid = 1'b0; iw_data = 16'h0000;
    wait_done();
    chk(int'(bmem['h666]) == ev, "R8", "dest after held words", bmem['h666], ev);
    repeat (2) @(negedge clk);
    chk(!busy, "R8", "no stray start", busy, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule